// File: doc/BRIEF.md
# Two-Bank Interleaved Page-Mode Memory Controller

This block sits between a request source (a stream scheduler or a plain scalar load/store path) and two interleaved banks of fast-page-mode memory. Each request carries a word address, a read/write direction and, for writes, a data word. The lowest address bit picks the bank. Each bank remembers which row it has open. An access to that row completes after a short page-hit delay. An access to any other row pays the longer page-miss delay, which covers closing the old row and opening the new one.

The two banks work independently. A long miss in one bank does not hold up traffic to the other. When the source alternates between the banks on open rows, the block accepts one request and returns one response every cycle. Whenever the data direction flips between read and write, one bus turnaround cycle is lost. Every accepted request gets a running sequence number, so the source can reorder responses that arrive on the two bank lanes.

The storage behind each bank is modelled as a plain array, so the block can be run on its own. Its timing comes only from the hit/miss latency rule.

Top module: `ilv_page_ctrl`

## Requirements
- R1: Out of reset no response is valid, `req_ready` is high, and neither bank has an open row, so the first access to each bank takes the miss latency of 7 cycles.
- R2: Address bit 0 selects the bank. Bits [8:1] are the column within a 1 KB page of 32-bit words. The bits above bit 8 are the row. The response appears only on the lane of the selected bank (lane 0 = bits [0], [31:0], [3:0] of the packed outputs).
- R3: A request accepted on clock edge e, whose row equals the bank's open row, produces its response on edge e+2.
- R4: A request accepted on edge e, whose row differs from the open row (or when no row is open), produces its response on edge e+7. Its row then becomes the bank's open row.
- R5: A bank takes a new request no earlier than the edge on which its previous response appears. A bank that is busy, even with a miss, never delays acceptance for the other bank.
- R6: Same-direction page hits that alternate between the banks are accepted on consecutive cycles, and their responses come back on consecutive cycles.
- R7: A request whose direction (`req_wr`) differs from the previously accepted request is not accepted in the first cycle it is presented. A same-direction request carries no such penalty.
- R8: Each accepted request receives a 4-bit sequence number. The number starts at 0 after reset, rises by one per acceptance and wraps. The response returns that number and the request's write flag.
- R9: A read returns the most recent data written to that address. A write response carries zero data.
- R10: At most one request is accepted per cycle, and every accepted request yields exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Word address: row, column, bank bit |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 2 | Per-bank response strobe |
| rsp_wr | output | 2 | Per-bank response is a write acknowledge |
| rsp_seq | output | 8 | Per-bank sequence number, 4 bits per lane |
| rsp_data | output | 64 | Per-bank read data, 32 bits per lane |

## Verification
The assertions assume that a presented request stays stable until it is accepted. The turnaround check, for example, relies on the request already having been pending in the cycle before a direction switch is accepted. The bench's driver only changes the request after an accepting edge, and inserts idle cycles only with `req_valid` low. The latency and response-spacing checks also assume a hit latency of at least two cycles, which the default parameters give. The random phase draws addresses from 64 locations that a directed phase has already written, so every read has a defined expected value.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int NUM_BANKS = 2;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } dir_e;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int DATA_W   = 32,
  parameter int COL_W    = 8,
  parameter int ROW_W    = 2,
  parameter int SEQ_W    = 4,
  parameter int HIT_LAT  = 2,
  parameter int MISS_LAT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              acc_wr,
  input  logic [COL_W-1:0]  acc_col,
  input  logic [ROW_W-1:0]  acc_row,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [SEQ_W-1:0]  acc_seq,
  output logic              free,
  output logic              rsp_valid,
  output logic              rsp_wr,
  output logic [SEQ_W-1:0]  rsp_seq,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int CNT_W = $clog2(MISS_LAT + 1);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] HIT_LOAD  = CNT_W'(HIT_LAT - 1);
  localparam logic [CNT_W-1:0] MISS_LOAD = CNT_W'(MISS_LAT - 1);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ROW_W-1:0]  open_row_q, open_row_d;
  logic              row_ok_q, row_ok_d;
  logic              op_wr_q;
  logic [IDX_W-1:0]  op_idx_q;
  logic [DATA_W-1:0] op_wdata_q;
  logic [SEQ_W-1:0]  op_seq_q;
  logic              rsp_valid_q, rsp_valid_d;
  logic              rsp_wr_q, rsp_wr_d;
  logic [SEQ_W-1:0]  rsp_seq_q, rsp_seq_d;
  logic [DATA_W-1:0] rsp_data_q;
  logic [DATA_W-1:0] mem [DEPTH];

  logic hit, done;

  assign hit  = row_ok_q && (open_row_q == acc_row);
  assign done = busy_q && (cnt_q == '0);
  assign free = !busy_q || done;

  // next-state
  always_comb begin
    busy_d      = busy_q;
    cnt_d       = cnt_q;
    open_row_d  = open_row_q;
    row_ok_d    = row_ok_q;
    rsp_valid_d = done;
    rsp_wr_d    = rsp_wr_q;
    rsp_seq_d   = rsp_seq_q;
    if (busy_q && (cnt_q != '0)) cnt_d = cnt_q - 1'b1;
    if (done) begin
      busy_d    = 1'b0;
      rsp_wr_d  = op_wr_q;
      rsp_seq_d = op_seq_q;
    end
    if (acc) begin
      busy_d     = 1'b1;
      cnt_d      = hit ? HIT_LOAD : MISS_LOAD;
      open_row_d = acc_row;
      row_ok_d   = 1'b1;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      cnt_q       <= '0;
      open_row_q  <= '0;
      row_ok_q    <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_wr_q    <= 1'b0;
      rsp_seq_q   <= '0;
      op_wr_q     <= 1'b0;
      op_idx_q    <= '0;
      op_seq_q    <= '0;
    end else begin
      busy_q      <= busy_d;
      cnt_q       <= cnt_d;
      open_row_q  <= open_row_d;
      row_ok_q    <= row_ok_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_wr_q    <= rsp_wr_d;
      rsp_seq_q   <= rsp_seq_d;
      if (acc) begin
        op_wr_q  <= acc_wr;
        op_idx_q <= {acc_row, acc_col};
        op_seq_q <= acc_seq;
      end
    end
  end

  // data path, no reset
  always_ff @(posedge clk) begin
    if (acc) op_wdata_q <= acc_wdata;
  end

  always_ff @(posedge clk) begin
    if (done) begin
      if (op_wr_q) begin
        mem[op_idx_q] <= op_wdata_q;
        rsp_data_q    <= '0;
      end else begin
        rsp_data_q    <= mem[op_idx_q];
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_wr    = rsp_wr_q;
  assign rsp_seq   = rsp_seq_q;
  assign rsp_data  = rsp_data_q;

  // checker state: cycles elapsed since the access was taken
  logic [7:0] chk_age, chk_need;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_age  <= '0;
      chk_need <= '0;
    end else if (acc) begin
      chk_age  <= '0;
      chk_need <= hit ? 8'(HIT_LAT) : 8'(MISS_LAT);
    end else if (busy_q) begin
      chk_age  <= chk_age + 8'd1;
    end
  end

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (chk_age + 8'd1 == chk_need)); // R4
  AST_TAKE_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> free); // R5
  AST_RSP_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_q |=> !rsp_valid_q); // R5
endmodule

// File: rtl/ilv_issue.sv
module ilv_issue
  import ilv_pkg::*;
#(
  parameter int SEQ_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_wr,
  input  logic                 req_bank,
  input  logic [NUM_BANKS-1:0] bank_free,
  output logic                 req_ready,
  output logic [NUM_BANKS-1:0] acc,
  output logic [SEQ_W-1:0]     acc_seq
);
  dir_e             last_dir_q, last_dir_d;
  logic             last_ok_q, last_ok_d;
  logic             gap_q, gap_d;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic             dir_flip, take;

  assign dir_flip  = last_ok_q && (dir_e'(req_wr) != last_dir_q);
  assign req_ready = bank_free[req_bank] && (!dir_flip || gap_q);
  assign take      = req_valid && req_ready;
  assign acc_seq   = seq_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_steer
    assign acc[b] = take && (req_bank == 1'(b));
  end

  // next-state
  always_comb begin
    last_dir_d = last_dir_q;
    last_ok_d  = last_ok_q;
    gap_d      = gap_q;
    seq_d      = seq_q;
    if (take) begin
      last_dir_d = dir_e'(req_wr);
      last_ok_d  = 1'b1;
      gap_d      = 1'b0;
      seq_d      = seq_q + 1'b1;
    end else if (req_valid && dir_flip) begin
      gap_d      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_dir_q <= DIR_RD;
      last_ok_q  <= 1'b0;
      gap_q      <= 1'b0;
      seq_q      <= '0;
    end else begin
      last_dir_q <= last_dir_d;
      last_ok_q  <= last_ok_d;
      gap_q      <= gap_d;
      seq_q      <= seq_d;
    end
  end

  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc)); // R10
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (seq_q == $past(seq_q) + 1'b1)); // R8
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dir_flip) |-> $past(req_valid)); // R7
endmodule

// File: rtl/ilv_page_ctrl.sv
module ilv_page_ctrl
  import ilv_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int COL_W    = 8,
  parameter int ROW_W    = 2,
  parameter int SEQ_W    = 4,
  parameter int HIT_LAT  = 2,
  parameter int MISS_LAT = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_wr,
  input  logic [ROW_W+COL_W:0]        req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic [NUM_BANKS-1:0]        rsp_valid,
  output logic [NUM_BANKS-1:0]        rsp_wr,
  output logic [NUM_BANKS*SEQ_W-1:0]  rsp_seq,
  output logic [NUM_BANKS*DATA_W-1:0] rsp_data
);
  localparam int ADDR_W = ROW_W + COL_W + 1;

  logic                 sel_bank;
  logic [COL_W-1:0]     sel_col;
  logic [ROW_W-1:0]     sel_row;
  logic [NUM_BANKS-1:0] bank_free, bank_acc;
  logic [SEQ_W-1:0]     next_seq;

  assign sel_bank = req_addr[0];
  assign sel_col  = req_addr[COL_W:1];
  assign sel_row  = req_addr[ADDR_W-1:COL_W+1];

  ilv_issue #(.SEQ_W(SEQ_W)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_wr    (req_wr),
    .req_bank  (sel_bank),
    .bank_free (bank_free),
    .req_ready (req_ready),
    .acc       (bank_acc),
    .acc_seq   (next_seq)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ilv_bank #(
      .DATA_W   (DATA_W),
      .COL_W    (COL_W),
      .ROW_W    (ROW_W),
      .SEQ_W    (SEQ_W),
      .HIT_LAT  (HIT_LAT),
      .MISS_LAT (MISS_LAT)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (bank_acc[b]),
      .acc_wr    (req_wr),
      .acc_col   (sel_col),
      .acc_row   (sel_row),
      .acc_wdata (req_wdata),
      .acc_seq   (next_seq),
      .free      (bank_free[b]),
      .rsp_valid (rsp_valid[b]),
      .rsp_wr    (rsp_wr[b]),
      .rsp_seq   (rsp_seq[b*SEQ_W +: SEQ_W]),
      .rsp_data  (rsp_data[b*DATA_W +: DATA_W])
    );
  end
endmodule

// File: tb/sim_ilv_page_ctrl.sv
module sim_ilv_page_ctrl;
  localparam int DW = 32, CW = 8, RW = 2, SW = 4, AW = 1 + CW + RW;
  localparam int HIT = 2, MISS = 7, LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 1'b0, req_ready, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] rsp_valid, rsp_wr;
  logic [2*SW-1:0] rsp_seq;
  logic [2*DW-1:0] rsp_data;

  ilv_page_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_wr(rsp_wr), .rsp_seq(rsp_seq), .rsp_data(rsp_data)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc = cyc + 1;

  // reference model
  logic [DW-1:0] ref_mem [1 << AW];
  bit            ref_known [1 << AW];
  logic [RW-1:0] m_row [2];
  bit            m_ok [2];
  logic [SW-1:0] m_seq = '0;

  // per-bank scoreboard
  int            q_due [2][8];
  int            q_lat [2][8];
  logic [SW-1:0] q_seq [2][8];
  bit            q_wr  [2][8];
  bit            q_kn  [2][8];
  logic [DW-1:0] q_dat [2][8];
  int            q_hd [2], q_tl [2];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int row, input int col, input int bank);
    return {RW'(row), CW'(col), 1'(bank)};
  endfunction

  // response monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int b = 0; b < 2; b++) begin
        if (rsp_valid[b]) begin
          if (q_tl[b] == q_hd[b]) begin
            chk(1'b0, "R10", "response with nothing outstanding", 64'(b), 64'hff);
          end else begin
            int h;
            h = q_hd[b] % 8;
            chk(cyc == q_due[b][h], (q_lat[b][h] == HIT) ? "R3" : "R4",
                "response cycle", 64'(cyc), 64'(q_due[b][h]));
            chk(rsp_seq[b*SW +: SW] == q_seq[b][h], "R8", "sequence tag",
                64'(rsp_seq[b*SW +: SW]), 64'(q_seq[b][h]));
            chk(rsp_wr[b] == q_wr[b][h], "R8", "write flag",
                64'(rsp_wr[b]), 64'(q_wr[b][h]));
            if (q_kn[b][h])
              chk(rsp_data[b*DW +: DW] == q_dat[b][h], "R9", "response data",
                  64'(rsp_data[b*DW +: DW]), 64'(q_dat[b][h]));
            q_hd[b] = q_hd[b] + 1;
          end
        end
      end
    end
  end

  // called just after a negedge; returns after the negedge that follows acceptance
  task automatic send(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output int acc_cyc, output int due);
    int b, t, lat;
    logic [RW-1:0] row;
    req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    acc_cyc = cyc + 1;
    b   = int'(a[0]);
    row = a[AW-1:CW+1];
    lat = (m_ok[b] && m_row[b] == row) ? HIT : MISS;
    m_ok[b] = 1'b1; m_row[b] = row;
    due = acc_cyc + lat;
    t = q_tl[b] % 8;
    q_due[b][t] = due; q_lat[b][t] = lat; q_seq[b][t] = m_seq; q_wr[b][t] = wr;
    q_kn[b][t]  = wr ? 1'b1 : ref_known[a];
    q_dat[b][t] = wr ? '0 : ref_mem[a];
    q_tl[b] = q_tl[b] + 1;
    m_seq = m_seq + 1'b1;
    if (wr) begin
      ref_mem[a] = d; ref_known[a] = 1'b1;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc > LIMIT && !finished) begin
      finished = 1;
      errors = errors + 1; checks = checks + 1;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int a0, d0, a1, d1, a2, d2, a3, d3;
    int accs [16];
    void'($urandom(32'h1a2b3c4d));
    for (int b = 0; b < 2; b++) begin
      q_hd[b] = 0; q_tl[b] = 0; m_ok[b] = 1'b0; m_row[b] = '0;
    end
    for (int i = 0; i < (1 << AW); i++) ref_known[i] = 1'b0;

    repeat (3) @(negedge clk);
    chk(rsp_valid == 2'b00, "R1", "no response in reset", 64'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(rsp_valid == 2'b00, "R1", "no response after reset", 64'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 1);

    // first access: miss; then same row: hit
    @(negedge clk);
    send(1'b1, mk(0, 0, 0), 32'hA5A5_0001, a0, d0);
    wait_to(a0 + 6);
    chk(rsp_valid[0] == 1'b0, "R1", "first access not done early", 64'(rsp_valid[0]), 0);
    wait_to(a0 + 7);
    chk(rsp_valid[0] == 1'b1, "R1", "first access miss latency", 64'(rsp_valid[0]), 1);
    send(1'b1, mk(0, 1, 0), 32'hA5A5_0002, a1, d1);
    wait_to(a1 + 1);
    chk(rsp_valid[0] == 1'b0, "R3", "hit not done early", 64'(rsp_valid[0]), 0);
    wait_to(a1 + 2);
    chk(rsp_valid[0] == 1'b1, "R3", "hit latency", 64'(rsp_valid[0]), 1);

    // populate 64 locations
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 8; c++)
        for (int b = 0; b < 2; b++)
          send(1'b1, mk(r, c, b), $urandom, a0, d0);
    wait_to(cyc + 10);

    // lane selection by bank bit
    send(1'b0, mk(2, 5, 1), 32'h0, a0, d0);
    wait_to(d0);
    chk(rsp_valid == 2'b10, "R2", "response only on bank 1 lane", 64'(rsp_valid), 2);
    wait_to(cyc + 10);

    // throughput: alternating hits on open rows
    send(1'b0, mk(1, 0, 0), 0, a0, d0);
    send(1'b0, mk(1, 0, 1), 0, a0, d0);
    for (int i = 0; i < 16; i++) send(1'b0, mk(1, i / 2, i % 2), 0, accs[i], d0);
    for (int i = 1; i < 16; i++)
      chk(accs[i] == accs[i-1] + 1, "R6", "back-to-back acceptance",
          64'(accs[i]), 64'(accs[i-1] + 1));
    wait_to(cyc + 10);

    // turnaround on direction switch
    send(1'b0, mk(1, 0, 0), 0, a0, d0);
    send(1'b1, mk(1, 0, 1), 32'h1234_5678, a1, d1);
    chk(a1 == a0 + 2, "R7", "read-to-write gap", 64'(a1), 64'(a0 + 2));
    send(1'b1, mk(1, 1, 0), 32'h8765_4321, a2, d2);
    chk(a2 == a1 + 1, "R7", "no gap same direction", 64'(a2), 64'(a1 + 1));
    wait_to(cyc + 10);

    // miss in bank 0 does not block bank 1
    send(1'b0, mk(3, 0, 0), 0, a0, d0);
    send(1'b0, mk(1, 2, 1), 0, a1, d1);
    chk(a1 == a0 + 1, "R5", "other bank not blocked", 64'(a1), 64'(a0 + 1));
    send(1'b0, mk(1, 3, 1), 0, a2, d2);
    chk(a2 == a1 + 2, "R5", "same bank waits for response", 64'(a2), 64'(a1 + 2));
    send(1'b0, mk(1, 4, 0), 0, a3, d3);
    chk(a3 == a0 + 7, "R5", "bank busy with miss", 64'(a3), 64'(a0 + 7));
    wait_to(cyc + 10);

    // random traffic over the populated locations
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 5 == 0) @(negedge clk);
      send(($urandom % 3) == 0, mk($urandom % 4, $urandom % 8, $urandom % 2),
           $urandom, a0, d0);
    end
    wait_to(cyc + 20);
    for (int b = 0; b < 2; b++)
      chk(q_hd[b] == q_tl[b], "R10", "all requests answered",
          64'(q_hd[b]), 64'(q_tl[b]));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule